// File: doc/BRIEF.md
# Compare-Triggered Converter Start Controller

This block ties a free-running 16-bit timer to the start logic of a 10-bit analog-to-digital converter. A compare register is checked against the timer on every cycle. When the compare mode field holds the special-event code and the timer reaches the compare value, the block emits a one-cycle event. That event always clears the timer, so the sampling period repeats without software. If the converter is enabled and idle, the event also raises the start/busy bit and begins an acquisition interval followed by a conversion. Software can start a conversion directly as well.

A built-in converter stub takes a start pulse, captures the value on `ain_value`, and returns it after a fixed number of cycles. On completion the sequencer clears the busy bit, stores the sample left- or right-justified across two result bytes, and sets a sticky interrupt flag. The sequencer is a three-state machine. SEQ_IDLE moves on a start request to SEQ_ACQ, or straight to SEQ_CONV when the acquisition code is 0. SEQ_ACQ moves to SEQ_CONV when its count expires. SEQ_CONV returns to SEQ_IDLE when the stub reports done.

Register map (byte addresses): 0 control, 1 configuration, 2 result high, 3 result low, 4 compare low, 5 compare high, 6 timer low, 7 timer high, 8 flag (bit 0), 9 compare mode (bits 3:0). Any other address reads 0.

Top module: `adc_event_trigger`

## Requirements
- R1: After reset, addresses 0 to 5, 8 and 9 read 0, `irq` is 0, and the timer high byte (address 7) reads 0 in the first cycles.
- R2: The timer advances by one every cycle. When the mode field (address 9, bits 3:0) is 4'b1011 and the timer equals the compare value C, the timer reads 0 on the next cycle, which gives a period of C+1 cycles.
- R3: With any other mode value the timer is never cleared by a match, and no conversion starts even when the converter is enabled.
- R4: An event that occurs while the enable bit (control bit 0) is set and the sequencer is idle sets the start/busy bit (control bit 1) on the following cycle.
- R5: An event that occurs while the enable bit is clear leaves the busy bit and `irq` at 0, but still clears the timer.
- R6: Acquisition codes 1 to 7 (configuration bits 5:3) last 2, 4, 6, 8, 12, 16 and 20 cycles. A conversion lasts 11·2^cs cycles, where cs is configuration bits 2:0. The flag rises exactly A + 11·2^cs + 2 cycles after the busy bit rises.
- R7: Acquisition code 0 skips acquisition, so the latency is 11·2^cs + 2 cycles.
- R8: On completion, in the same cycle, the busy bit returns to 0, the result bytes are updated and `irq` rises.
- R9: With the format bit (configuration bit 7) set, result high = {6'b0, d[9:8]} and result low = d[7:0]. With it clear, result high = d[9:2] and result low = {d[1:0], 6'b0}.
- R10: An event during a conversion neither restarts nor extends it.
- R11: The flag stays set until software writes address 8 with bit 0 = 0. A completion in the same cycle as that write leaves the flag set.
- R12: Control bits 7:6 and configuration bit 6 read 0. Control bits 5:2 select the channel and drive `ain_chan`.
- R13: A control write with bits 0 and 1 both set starts a conversion from idle. Writing bit 1 with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ain_value | input | 10 | Analog value seen by the converter stub |
| ain_chan | output | 4 | Selected input channel |
| irq | output | 1 | Sticky conversion-complete flag |

## Verification
The completion of a conversion and a software write that clears the flag can land on the same clock edge. The bench computes the exact completion edge from the latency formula. It places a clear write on that edge and expects the flag to stay set, then issues a clear on a later cycle and expects the flag to drop. A second overlap, between special events and a conversion in progress, is forced with a conversion that outlasts the timer period. It is judged by an unchanged end-to-end latency.

// File: rtl/adcev_pkg.sv
package adcev_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ACQ  = 2'd1,
        SEQ_CONV = 2'd2
    } seq_state_e;

    localparam logic [3:0] MODE_SPECIAL = 4'b1011;

    localparam logic [3:0] ADR_CTRL   = 4'd0;
    localparam logic [3:0] ADR_CFG    = 4'd1;
    localparam logic [3:0] ADR_RES_HI = 4'd2;
    localparam logic [3:0] ADR_RES_LO = 4'd3;
    localparam logic [3:0] ADR_CMP_LO = 4'd4;
    localparam logic [3:0] ADR_CMP_HI = 4'd5;
    localparam logic [3:0] ADR_TMR_LO = 4'd6;
    localparam logic [3:0] ADR_TMR_HI = 4'd7;
    localparam logic [3:0] ADR_FLAG   = 4'd8;
    localparam logic [3:0] ADR_MODE   = 4'd9;

    // acquisition length in clock cycles for each 3-bit code
    function automatic logic [4:0] acq_cycles(input logic [2:0] code);
        logic [4:0] n;
        unique case (code)
            3'd0: n = 5'd0;
            3'd1: n = 5'd2;
            3'd2: n = 5'd4;
            3'd3: n = 5'd6;
            3'd4: n = 5'd8;
            3'd5: n = 5'd12;
            3'd6: n = 5'd16;
            default: n = 5'd20;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/adcev_timer.sv
module adcev_timer
    import adcev_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode,
    input  logic [TMR_W-1:0] cmp,
    output logic [TMR_W-1:0] tmr,
    output logic             evt
);

    logic hit;
    assign hit = (mode == MODE_SPECIAL) && (tmr == cmp);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr <= '0;
            evt <= 1'b0;
        end else begin
            evt <= hit;
            tmr <= hit ? '0 : tmr + 1'b1;
        end
    end

    // R2: the cycle carrying the event sees a freshly cleared timer
    assert_evt_clears_timer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (tmr == '0));

    // R3: no event follows a cycle in another compare mode
    assert_no_evt_other_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_SPECIAL) |=> !evt);

endmodule

// File: rtl/adcev_conv_stub.sv
module adcev_conv_stub #(
    parameter int RES_W = 10,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic [RES_W-1:0] sample_in,
    output logic             done,
    output logic [RES_W-1:0] data
);

    logic             busy;
    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
            data <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                cnt  <= len - 1'b1;
                data <= sample_in;
            end else if (busy) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R8: a done pulse always marks the end of a busy interval
    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/adcev_seq.sv
module adcev_seq
    import adcev_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_start,
    input  logic             sw_start,
    input  logic [4:0]       acq_len,
    input  logic             fmt_right,
    input  logic             flag_clr,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             go,
    output logic             flag,
    output logic [7:0]       res_hi,
    output logic [7:0]       res_lo,
    output logic             conv_start
);

    localparam int PAD_W = 16 - RES_W;

    seq_state_e state_q, state_d;
    logic [4:0] acq_cnt;
    logic       start_req;
    logic [15:0] word;

    assign start_req = evt_start || sw_start;
    assign word = fmt_right ? {{PAD_W{1'b0}}, conv_data} : {conv_data, {PAD_W{1'b0}}};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (start_req) state_d = (acq_len == '0) ? SEQ_CONV : SEQ_ACQ;
            SEQ_ACQ:  if (acq_cnt == '0) state_d = SEQ_CONV;
            SEQ_CONV: if (conv_done) state_d = SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go         <= 1'b0;
            flag       <= 1'b0;
            res_hi     <= '0;
            res_lo     <= '0;
            acq_cnt    <= '0;
            conv_start <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start_req) begin
                        go      <= 1'b1;
                        acq_cnt <= acq_len - 1'b1;
                        if (acq_len == '0) conv_start <= 1'b1;
                    end
                end
                SEQ_ACQ: begin
                    acq_cnt <= acq_cnt - 1'b1;
                    if (acq_cnt == '0) conv_start <= 1'b1;
                end
                SEQ_CONV: begin
                    if (conv_done) begin
                        go     <= 1'b0;
                        res_hi <= word[15:8];
                        res_lo <= word[7:0];
                    end
                end
                default: go <= 1'b0;
            endcase
            if ((state_q == SEQ_CONV) && conv_done) flag <= 1'b1;
            else if (flag_clr)                      flag <= 1'b0;
        end
    end

    // R4: the busy bit covers every active state
    assert_busy_while_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SEQ_IDLE) |-> go);

    // R8: completion drops busy and raises the flag together
    assert_done_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SEQ_CONV) && conv_done) |=> (flag && !go));

    // R10: a start request during conversion does not leave the conversion state
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SEQ_CONV) && start_req && !conv_done) |=> (state_q == SEQ_CONV));

    // R11: a clear request never beats a completion
    assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SEQ_CONV) && conv_done && flag_clr) |=> flag);

endmodule

// File: rtl/adc_event_trigger.sv
module adc_event_trigger
    import adcev_pkg::*;
#(
    parameter int TMR_W     = 16,
    parameter int RES_W     = 10,
    parameter int CONV_TADS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [RES_W-1:0] ain_value,
    output logic [3:0]       ain_chan,
    output logic             irq
);

    localparam int LEN_W = $clog2(CONV_TADS * 128 + 1);

    logic             ctrl_en;
    logic [3:0]       ctrl_chan;
    logic             cfg_fmt;
    logic [2:0]       cfg_acq;
    logic [2:0]       cfg_cs;
    logic [TMR_W-1:0] cmp_q;
    logic [3:0]       mode_q;

    logic [TMR_W-1:0] tmr;
    logic             evt;
    logic             go, flag, conv_start, conv_done;
    logic [7:0]       res_hi, res_lo;
    logic [RES_W-1:0] conv_data;
    logic [LEN_W-1:0] conv_len;
    logic             sw_start, flag_clr;

    assign sw_start = reg_wr && (reg_addr == ADR_CTRL) && reg_wdata[0] && reg_wdata[1];
    assign flag_clr = reg_wr && (reg_addr == ADR_FLAG) && !reg_wdata[0];
    assign conv_len = LEN_W'(CONV_TADS) << cfg_cs;
    assign ain_chan = ctrl_chan;
    assign irq      = flag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_chan <= '0;
            cfg_fmt   <= 1'b0;
            cfg_acq   <= '0;
            cfg_cs    <= '0;
            cmp_q     <= '0;
            mode_q    <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                ADR_CTRL: begin
                    ctrl_en   <= reg_wdata[0];
                    ctrl_chan <= reg_wdata[5:2];
                end
                ADR_CFG: begin
                    cfg_fmt <= reg_wdata[7];
                    cfg_acq <= reg_wdata[5:3];
                    cfg_cs  <= reg_wdata[2:0];
                end
                ADR_CMP_LO: cmp_q[7:0]       <= reg_wdata;
                ADR_CMP_HI: cmp_q[TMR_W-1:8] <= reg_wdata[TMR_W-9:0];
                ADR_MODE:   mode_q           <= reg_wdata[3:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADR_CTRL:   reg_rdata = {2'b00, ctrl_chan, go, ctrl_en};
            ADR_CFG:    reg_rdata = {cfg_fmt, 1'b0, cfg_acq, cfg_cs};
            ADR_RES_HI: reg_rdata = res_hi;
            ADR_RES_LO: reg_rdata = res_lo;
            ADR_CMP_LO: reg_rdata = cmp_q[7:0];
            ADR_CMP_HI: reg_rdata = 8'(cmp_q[TMR_W-1:8]);
            ADR_TMR_LO: reg_rdata = tmr[7:0];
            ADR_TMR_HI: reg_rdata = 8'(tmr[TMR_W-1:8]);
            ADR_FLAG:   reg_rdata = {7'd0, flag};
            ADR_MODE:   reg_rdata = {4'd0, mode_q};
            default:    reg_rdata = 8'd0;
        endcase
    end

    adcev_timer #(.TMR_W(TMR_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (mode_q),
        .cmp  (cmp_q),
        .tmr  (tmr),
        .evt  (evt)
    );

    adcev_seq #(.RES_W(RES_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_start (evt && ctrl_en),
        .sw_start  (sw_start),
        .acq_len   (acq_cycles(cfg_acq)),
        .fmt_right (cfg_fmt),
        .flag_clr  (flag_clr),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .go        (go),
        .flag      (flag),
        .res_hi    (res_hi),
        .res_lo    (res_lo),
        .conv_start(conv_start)
    );

    adcev_conv_stub #(.RES_W(RES_W), .LEN_W(LEN_W)) u_stub (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (conv_start),
        .len      (conv_len),
        .sample_in(ain_value),
        .done     (conv_done),
        .data     (conv_data)
    );

    // R5: an event with the converter disabled leaves it idle
    assert_disabled_evt_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !ctrl_en && !go && !sw_start) |=> !go);

endmodule

// File: tb/adc_event_trigger_tb.sv
module adc_event_trigger_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [9:0] ain_value;
    logic [3:0] ain_chan;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    int unsigned seed_v;

    always #5 clk = ~clk;

    adc_event_trigger dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ain_value(ain_value),
        .ain_chan (ain_chan),
        .irq      (irq)
    );

    function automatic int exp_acq(input int code);
        int tbl[8] = '{0, 2, 4, 6, 8, 12, 16, 20};
        return tbl[code];
    endfunction

    function automatic int exp_latency(input int acq, input int cs);
        return exp_acq(acq) + 11 * (1 << cs) + 2;
    endfunction

    function automatic logic [7:0] exp_hi(input logic [9:0] d, input bit right);
        return right ? {6'd0, d[9:8]} : d[9:2];
    endfunction

    function automatic logic [7:0] exp_lo(input logic [9:0] d, input bit right);
        return right ? d[7:0] : {d[1:0], 6'd0};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // waits for the busy bit, then counts cycles until irq rises
    task automatic measure(output int lat, output bit ok);
        logic [7:0] d;
        int guard = 0;
        rd(4'd0, d);
        while (!d[1] && guard < 2000) begin
            @(negedge clk);
            rd(4'd0, d);
            guard++;
        end
        ok = d[1];
        lat = 0;
        guard = 0;
        while (!irq && guard < 5000) begin
            @(negedge clk);
            #1;
            lat++;
            guard++;
        end
        ok = ok && irq;
    endtask

    // samples the timer low byte each cycle; checks increment or clear after C
    task automatic check_period(input int c, input bit clears, input int ncyc,
                                input string req);
        logic [7:0] prev, cur, d;
        int bad = 0, bad_act = 0, bad_exp = 0, zeros = 0, busy_seen = 0;
        rd(4'd6, prev);
        for (int i = 0; i < ncyc; i++) begin
            logic [7:0] e;
            @(negedge clk);
            rd(4'd6, cur);
            e = (clears && prev == 8'(c)) ? 8'd0 : prev + 8'd1;
            if (cur != e && bad == 0) begin
                bad = 1; bad_act = cur; bad_exp = e;
            end
            if (cur == 8'd0) zeros++;
            if (irq) busy_seen++;
            rd(4'd0, d);
            if (d[1]) busy_seen++;
            prev = cur;
        end
        check(bad == 0, req, "timer sequence", bad_act, bad_exp);
        if (clears) check(zeros > 0, req, "timer cleared at least once", zeros, 1);
        check(busy_seen == 0, req, "no conversion activity", busy_seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int lat;
        bit ok;
        seed_v    = $urandom(32'd2024);
        rst_n     = 1'b0;
        reg_wr    = 1'b0;
        reg_addr  = 4'd0;
        reg_wdata = 8'd0;
        ain_value = 10'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 10; a++) begin
            if (a == 6) continue;
            rd(4'(a), d);
            check(d == 8'd0, "R1", $sformatf("reset read addr %0d", a), d, 0);
        end
        check(irq == 1'b0, "R1", "irq after reset", irq, 0);

        // R12 / R13: unimplemented bits and start without enable
        wr(4'd0, 8'hFC);
        rd(4'd0, d);
        check(d == 8'h3C, "R12", "control readback, bit1 without enable R13", d, 8'h3C);
        check(ain_chan == 4'hF, "R12", "channel output", ain_chan, 15);
        check(irq == 1'b0, "R13", "no start without enable", irq, 0);
        wr(4'd1, 8'hFF);
        rd(4'd1, d);
        check(d == 8'hBF, "R12", "config bit6 reads 0", d, 8'hBF);
        wr(4'd1, 8'h00);
        wr(4'd0, 8'h00);

        // R2 / R5: special events with the converter disabled
        wr(4'd4, 8'd200);
        wr(4'd5, 8'd0);
        wr(4'd9, 8'h0B);
        rd(4'd9, d);
        check(d == 8'h0B, "R2", "mode readback", d, 8'h0B);
        check_period(200, 1'b1, 500, "R5");
        check_period(200, 1'b1, 300, "R2");

        // R4 R6 R7 R8 R9 R11: random conversions triggered by events
        for (int t = 0; t < 6; t++) begin
            int acq, cs, chan;
            bit fmt;
            acq  = (t == 0) ? 0 : int'($urandom % 8);
            cs   = int'($urandom % 4);
            fmt  = (t == 1) ? 1'b1 : ((t == 2) ? 1'b0 : 1'($urandom % 2));
            chan = int'($urandom % 16);
            ain_value = 10'($urandom % 1024);
            if (t == 3) ain_value = 10'h3FF;
            wr(4'd1, {fmt, 1'b0, 3'(acq), 3'(cs)});
            wr(4'd0, {2'b00, 4'(chan), 1'b0, 1'b1});
            check(ain_chan == 4'(chan), "R12", "channel select", ain_chan, chan);
            measure(lat, ok);
            check(ok, "R4", "event started conversion", ok, 1);
            check(lat == exp_latency(acq, cs), (acq == 0) ? "R7" : "R6",
                  "start-to-flag latency", lat, exp_latency(acq, cs));
            rd(4'd0, d);
            check(d[1] == 1'b0, "R8", "busy cleared at completion", d[1], 0);
            rd(4'd2, d);
            check(d == exp_hi(ain_value, fmt), "R9", "result high byte", d,
                  exp_hi(ain_value, fmt));
            rd(4'd3, d);
            check(d == exp_lo(ain_value, fmt), "R9", "result low byte", d,
                  exp_lo(ain_value, fmt));
            wr(4'd0, 8'h00);
            repeat (5) @(negedge clk);
            check(irq == 1'b1, "R11", "flag persists", irq, 1);
            wr(4'd8, 8'h00);
            #1;
            check(irq == 1'b0, "R11", "flag cleared by write", irq, 0);
        end

        // R10: events during a long conversion do not restart it
        ain_value = 10'h155;
        wr(4'd1, {1'b1, 1'b0, 3'd7, 3'd5});
        wr(4'd0, 8'h01);
        measure(lat, ok);
        check(ok && lat == exp_latency(7, 5), "R10", "latency with events mid-conversion",
              lat, exp_latency(7, 5));
        rd(4'd3, d);
        check(d == 8'h55, "R10", "result after overlapping events", d, 8'h55);
        wr(4'd0, 8'h00);
        wr(4'd8, 8'h00);

        // R3: other mode, enabled converter, no clears and no conversion
        wr(4'd9, 8'h0A);
        wr(4'd0, 8'h01);
        check_period(200, 1'b0, 300, "R3");

        // R13 + R11: software start, clear write on the completion edge
        ain_value = 10'h2A7;
        wr(4'd1, {1'b0, 1'b0, 3'd1, 3'd0});
        @(negedge clk);
        reg_addr  = 4'd0;
        reg_wdata = 8'h03;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        rd(4'd0, d);
        check(d[1] == 1'b1, "R13", "software start sets busy", d[1], 1);
        repeat (exp_latency(1, 0) - 1) @(negedge clk);
        reg_addr  = 4'd8;
        reg_wdata = 8'h00;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        #1;
        check(irq == 1'b1, "R11", "completion wins over same-cycle clear", irq, 1);
        rd(4'd2, d);
        check(d == 8'hA9, "R13", "software-started result high", d, 8'hA9);
        wr(4'd8, 8'h00);
        #1;
        check(irq == 1'b0, "R11", "later clear drops flag", irq, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule